// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the interrupt control logic of a small 16-bit processor. All interrupting devices share one request line. The block samples that line only at instruction boundaries, which the decoder marks with a completion strobe. If the interrupt-enable flag permits, the block accepts the request. It then stalls the core and performs a fixed three-step entry over a simple request/ready memory port. First it stores the return program counter into memory word 0. Next it reads the handler pointer from word 1. Finally it loads the program counter with that pointer. Acceptance also turns the enable flag off.

The decoder reports enable and disable commands as strobes that come with the completion strobe of the instruction that carries them. A disable takes effect at once. An enable only arms the flag, and the flag turns on when the next instruction completes. This leaves exactly one instruction, normally the return jump, that cannot be interrupted. When power comes back with the key-lock input set, the block reads the restart pointer from word 2 and jumps there, with no store. Instruction decode and the datapath are outside the block. They appear here only as strobes, the current program counter and a program-counter load port.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only in a cycle where `insn_done` is high, `irq_line` is high, `busy` is low and the flag is on or armed. A request seen while `insn_done` is low is not accepted and leaves `busy` low.
- R2: In the cycle after acceptance the block issues a write: `mem_req`=1, `mem_we`=1, `mem_addr`=0 and `mem_wdata` equal to the `pc_cur` value captured at acceptance. Address, data and write strobe stay unchanged until `mem_ready` is seen high.
- R3: In the cycle after the write handshake the block issues a read: `mem_req`=1, `mem_we`=0 and `mem_addr`=1. These stay held until `mem_ready` is high.
- R4: In the cycle after the read handshake, `pc_load` and `irq_taken` are high for exactly one cycle. In that cycle `pc_new` equals the `mem_rdata` value from the handshake.
- R5: `int_en` reads 0 from the cycle after acceptance onward, until it is enabled again.
- R6: An enable command does not change `int_en` and does not allow acceptance at its own boundary. The flag goes to 1 after the next completed instruction. A request can be accepted at that next boundary.
- R7: A disable command clears `int_en` in the next cycle, cancels an armed enable, and blocks acceptance at its own boundary.
- R8: While idle, `power_up` together with `key_lock` starts a read with `mem_we`=0 and `mem_addr`=2, and performs no write. It then gives one cycle of `pc_load` and `restart_taken`, with `pc_new` equal to the data read. It also clears the flag. `power_up` without `key_lock` has no effect.
- R9: After reset, `int_en`, `busy`, `mem_req`, `pc_load`, `irq_taken` and `restart_taken` are all 0.
- R10: While `busy` is high, `insn_done`, `cmd_inten` and `cmd_intds` are ignored.
- R11: `busy` is high from the cycle after acceptance (or restart start) up to and including the `pc_load` cycle, and low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | 1 | Shared wired-OR interrupt request |
| insn_done | input | 1 | An instruction completes this cycle |
| cmd_inten | input | 1 | The completing instruction is an enable command |
| cmd_intds | input | 1 | The completing instruction is a disable command |
| pc_cur | input | W | Return address (next instruction) at the boundary |
| power_up | input | 1 | Power restored strobe |
| key_lock | input | 1 | Front key in locked position |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | W | Memory word address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the access |
| pc_load | output | 1 | Load program counter from pc_new |
| pc_new | output | W | New program counter value |
| irq_taken | output | 1 | Interrupt entry completed |
| restart_taken | output | 1 | Restart entry completed |
| int_en | output | 1 | Interrupt-enable flag |
| busy | output | 1 | Sequence in progress, core stalled |

## Verification
All outputs come from registers. A decision made at one clock edge therefore shows up one cycle later. The flag changes one cycle after the boundary that changes it. The write request appears one cycle after acceptance. The read request appears one cycle after each write handshake, and the program-counter load one cycle after the read handshake. The bench applies inputs on falling edges. A behavioural model advances on each rising edge, and the design's outputs are compared against it on the next falling edge, so every comparison looks at exactly one registered step. The bench memory answers after a wait it chooses. With zero and nonzero waits, the held request and the handshake-to-next-step timing are both checked.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SAVE  = 2'd1,
    SQ_FETCH = 2'd2,
    SQ_JUMP  = 2'd3
  } sq_state_t;

  localparam int unsigned RET_SLOT = 0;
  localparam int unsigned VEC_SLOT = 1;
  localparam int unsigned RST_SLOT = 2;

  // word the pointer fetch reads from
  function automatic int unsigned fetch_slot(input logic is_restart);
    return is_restart ? RST_SLOT : VEC_SLOT;
  endfunction

  // acceptance rule at an instruction boundary
  function automatic logic may_accept(input logic boundary, input logic req,
                                      input logic dis_cmd, input logic flag,
                                      input logic armed);
    return boundary & req & ~dis_cmd & (flag | armed);
  endfunction

endpackage

// File: rtl/irq_en_ctrl.sv
module irq_en_ctrl
  import irq_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic insn_done,
  input  logic cmd_inten,
  input  logic cmd_intds,
  input  logic irq_line,
  input  logic seq_idle,
  input  logic restart_go,
  output logic int_en,
  output logic en_armed,
  output logic accept
);

  logic boundary;

  assign boundary = insn_done & seq_idle & ~restart_go;
  assign accept   = may_accept(boundary, irq_line, cmd_intds, int_en, en_armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en   <= 1'b0;
      en_armed <= 1'b0;
    end else if (restart_go) begin
      int_en   <= 1'b0;
      en_armed <= 1'b0;
    end else if (boundary) begin
      if (cmd_intds || accept) begin
        int_en   <= 1'b0;
        en_armed <= 1'b0;
      end else if (cmd_inten) begin
        if (!int_en) en_armed <= 1'b1;
      end else if (en_armed) begin
        int_en   <= 1'b1;
        en_armed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_mem_fsm.sv
module irq_mem_fsm
  import irq_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         restart_go,
  input  logic [W-1:0] ret_pc,
  input  logic         mem_ready,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         pc_load,
  output logic [W-1:0] pc_new,
  output logic         irq_taken,
  output logic         restart_taken,
  output logic         seq_idle
);

  localparam logic [W-1:0] RET_ADDR = W'(RET_SLOT);

  sq_state_t    state;
  logic [W-1:0] ret_q;
  logic [W-1:0] vec_q;
  logic         rst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      ret_q <= '0;
      vec_q <= '0;
      rst_q <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (restart_go) begin
            state <= SQ_FETCH;
            rst_q <= 1'b1;
          end else if (accept) begin
            state <= SQ_SAVE;
            rst_q <= 1'b0;
            ret_q <= ret_pc;
          end
        end
        SQ_SAVE:  if (mem_ready) state <= SQ_FETCH;
        SQ_FETCH: begin
          if (mem_ready) begin
            vec_q <= mem_rdata;
            state <= SQ_JUMP;
          end
        end
        SQ_JUMP:  state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    seq_idle      = (state == SQ_IDLE);
    mem_req       = (state == SQ_SAVE) || (state == SQ_FETCH);
    mem_we        = (state == SQ_SAVE);
    mem_addr      = (state == SQ_SAVE) ? RET_ADDR : W'(fetch_slot(rst_q));
    mem_wdata     = ret_q;
    pc_load       = (state == SQ_JUMP);
    pc_new        = vec_q;
    irq_taken     = pc_load & ~rst_q;
    restart_taken = pc_load & rst_q;
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq_line,
  input  logic         insn_done,
  input  logic         cmd_inten,
  input  logic         cmd_intds,
  input  logic [W-1:0] pc_cur,
  input  logic         power_up,
  input  logic         key_lock,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ready,
  output logic         pc_load,
  output logic [W-1:0] pc_new,
  output logic         irq_taken,
  output logic         restart_taken,
  output logic         int_en,
  output logic         busy
);

  logic seq_idle;
  logic restart_go;
  logic accept_evt;
  logic en_armed;

  assign restart_go = power_up & key_lock & seq_idle;
  assign busy       = ~seq_idle;

  irq_en_ctrl u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_done (insn_done),
    .cmd_inten (cmd_inten),
    .cmd_intds (cmd_intds),
    .irq_line  (irq_line),
    .seq_idle  (seq_idle),
    .restart_go(restart_go),
    .int_en    (int_en),
    .en_armed  (en_armed),
    .accept    (accept_evt)
  );

  irq_mem_fsm #(.W(W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept_evt),
    .restart_go   (restart_go),
    .ret_pc       (pc_cur),
    .mem_ready    (mem_ready),
    .mem_rdata    (mem_rdata),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .pc_load      (pc_load),
    .pc_new       (pc_new),
    .irq_taken    (irq_taken),
    .restart_taken(restart_taken),
    .seq_idle     (seq_idle)
  );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq_line,
  input logic         insn_done,
  input logic         cmd_inten,
  input logic         cmd_intds,
  input logic         power_up,
  input logic         key_lock,
  input logic         mem_req,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         mem_ready,
  input logic         pc_load,
  input logic         irq_taken,
  input logic         restart_taken,
  input logic         int_en,
  input logic         busy,
  input logic         accept_evt
);

  a_r1_accept_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> insn_done && irq_line && !busy);

  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r3_read_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ready |=> mem_req && !mem_we);

  a_r4_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);

  a_r4_taken_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> pc_load && !restart_taken);

  a_r5_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !int_en && busy);

  a_r6_enable_delayed: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done && cmd_inten && !int_en && !busy && !(power_up && key_lock) |=> !int_en);

  a_r7_disable_now: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done && cmd_intds && !busy |=> !int_en);

  a_r8_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
    restart_taken |-> pc_load);

  a_r11_busy_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> busy);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_line     (irq_line),
  .insn_done    (insn_done),
  .cmd_inten    (cmd_inten),
  .cmd_intds    (cmd_intds),
  .power_up     (power_up),
  .key_lock     (key_lock),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ready    (mem_ready),
  .pc_load      (pc_load),
  .irq_taken    (irq_taken),
  .restart_taken(restart_taken),
  .int_en       (int_en),
  .busy         (busy),
  .accept_evt   (accept_evt)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_line = 1'b0, insn_done = 1'b0, cmd_inten = 1'b0, cmd_intds = 1'b0;
  logic power_up = 1'b0, key_lock = 1'b0;
  logic [W-1:0] pc_cur = '0;
  logic mem_req, mem_we, pc_load, irq_taken, restart_taken, int_en, busy;
  logic [W-1:0] mem_addr, mem_wdata, pc_new;
  logic [W-1:0] mem_rdata = '0;
  logic mem_ready = 1'b0;

  always #10 clk = ~clk;

  irq_entry_seq #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .insn_done(insn_done),
    .cmd_inten(cmd_inten), .cmd_intds(cmd_intds), .pc_cur(pc_cur),
    .power_up(power_up), .key_lock(key_lock), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .pc_load(pc_load), .pc_new(pc_new),
    .irq_taken(irq_taken), .restart_taken(restart_taken), .int_en(int_en), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  int lat = 0, wcnt = 0;
  int n_irq = 0, n_rst = 0;
  logic [W-1:0] last_pc = '0;
  logic [W-1:0] bm [0:3];
  bit done_flag = 0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 store, 2 pointer read, 3 load
  int ph = 0;
  bit m_en = 0, m_arm = 0, m_rs = 0;
  logic [W-1:0] m_ret = '0, m_vec = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_en = 0; m_arm = 0; m_rs = 0; m_ret = '0; m_vec = '0;
    end else begin
      case (ph)
        0: begin
          if (power_up && key_lock) begin
            ph = 2; m_rs = 1; m_en = 0; m_arm = 0;
          end else if (insn_done) begin
            if (cmd_intds) begin m_en = 0; m_arm = 0; end
            else if (irq_line && (m_en || m_arm)) begin
              m_en = 0; m_arm = 0; ph = 1; m_rs = 0; m_ret = pc_cur;
            end else if (cmd_inten) begin if (!m_en) m_arm = 1; end
            else if (m_arm) begin m_en = 1; m_arm = 0; end
          end
        end
        1: if (mem_ready) ph = 2;
        2: if (mem_ready) begin m_vec = mem_rdata; ph = 3; end
        default: ph = 0;
      endcase
    end
  end

  // per-cycle compare, then memory model drive
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5 int_en", int_en, m_en);
      check("R11 busy", busy, ph != 0);
      check("R2 mem_req", mem_req, ph == 1 || ph == 2);
      if (ph == 1) begin
        check("R2 store we", mem_we, 1);
        check("R2 store addr", mem_addr, 0);
        check("R2 store data", mem_wdata, m_ret);
      end
      if (ph == 2) begin
        check("R3 read we", mem_we, 0);
        check("R3 read addr", mem_addr, m_rs ? 2 : 1);
      end
      check("R4 pc_load", pc_load, ph == 3);
      check("R4 irq_taken", irq_taken, ph == 3 && !m_rs);
      check("R8 restart_taken", restart_taken, ph == 3 && m_rs);
      if (ph == 3) check("R4 pc_new", pc_new, m_vec);
      if (pc_load) last_pc = pc_new;
      if (irq_taken) n_irq++;
      if (restart_taken) n_rst++;
    end
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready = 1'b1; wcnt = 0;
        mem_rdata = bm[mem_addr[1:0]];
      end else wcnt++;
    end
  end

  always @(posedge clk)
    if (rst_n && mem_req && mem_ready && mem_we) bm[mem_addr[1:0]] <= mem_wdata;

  task automatic step(input bit en, input bit ds, input logic [W-1:0] pc);
    @(negedge clk);
    insn_done = 1; cmd_inten = en; cmd_intds = ds; pc_cur = pc;
    @(negedge clk);
    insn_done = 0; cmd_inten = 0; cmd_intds = 0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic finish_up;
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int k;
    bm[0] = 16'h0000; bm[1] = 16'h0400; bm[2] = 16'h0800; bm[3] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check("R9 int_en", int_en, 0);
    check("R9 busy", busy, 0);
    check("R9 mem_req", mem_req, 0);
    check("R9 pc_load", pc_load, 0);

    // R1 request while disabled, and request without boundary
    irq_line = 1;
    step(0, 0, 16'h0010);
    step(0, 0, 16'h0011);
    repeat (3) @(negedge clk);
    check("R1 no entry while disabled", n_irq, 0);
    check("R1 busy stays low", busy, 0);

    // R6 enable: not taken at own boundary, taken at the next
    lat = 0;
    step(1, 0, 16'h0020);
    check("R6 flag still off", int_en, 0);
    check("R6 no entry at enable", busy, 0);
    step(0, 0, 16'h1234);
    check("R6 entry at following boundary", busy, 1);
    wait_idle();
    check("R2 return stored", bm[0], 16'h1234);
    check("R4 handler loaded", last_pc, 16'h0400);
    check("R4 one entry", n_irq, 1);
    check("R5 flag off after entry", int_en, 0);

    // R7 enable then disable cancels armed enable
    step(1, 0, 16'h0030);
    step(0, 1, 16'h0031);
    check("R7 flag off", int_en, 0);
    step(0, 0, 16'h0032);
    check("R7 no entry after cancel", busy, 0);

    // R7 full enable with request low, then disable with request high
    irq_line = 0;
    step(1, 0, 16'h0040);
    step(0, 0, 16'h0041);
    check("R6 flag on after follower", int_en, 1);
    irq_line = 1;
    step(0, 1, 16'h0042);
    check("R7 disable blocks entry", busy, 0);
    check("R7 flag cleared", int_en, 0);

    // R10 commands ignored while busy, R2/R3 held with memory wait
    irq_line = 0;
    step(1, 0, 16'h0050);
    step(0, 0, 16'h0051);
    bm[1] = 16'h0A00;
    lat = 3;
    irq_line = 1;
    step(0, 0, 16'h5555);
    irq_line = 0;
    for (k = 0; k < 3; k++) step(1, 0, 16'h0060);
    wait_idle();
    check("R2 return stored with wait", bm[0], 16'h5555);
    check("R4 handler with wait", last_pc, 16'h0A00);
    check("R10 enable during busy ignored", int_en, 0);
    step(0, 0, 16'h0061);
    check("R10 no arming left over", int_en, 0);

    // R8 restart: without key ignored, with key via word 2
    lat = 1;
    @(negedge clk); power_up = 1;
    @(negedge clk); power_up = 0;
    check("R8 no restart without key", busy, 0);
    key_lock = 1;
    @(negedge clk); power_up = 1;
    @(negedge clk); power_up = 0; key_lock = 0;
    check("R8 restart busy", busy, 1);
    wait_idle();
    check("R8 restart pointer", last_pc, 16'h0800);
    check("R8 one restart", n_rst, 1);
    check("R8 no store", bm[0], 16'h5555);
    check("R8 entries unchanged", n_irq, 2);
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule